// File: doc/BRIEF.md
# Pulse-Swallow Feedback and Reference Divider

This block divides a fast clock down to the phase-comparison rate of a frequency synthesizer. The feedback path is built like a pulse-swallow divider: a prescaler that counts 32 or 33 input cycles, steered by a swallow count A, and a main count B of prescaler cycles. Each output period covers 32·B + A input cycles. During the first A prescaler cycles of a period the prescaler counts 33, and for the remaining B − A cycles it counts 32. The output is a single-cycle pulse in the last input cycle of each period.

A companion reference divider counts R cycles of the same clock and pulses once per R cycles. Both dividers take their settings from a configuration source through a load strobe. A legal setting is held as pending and becomes active only at the next period boundary of its own divider, so a running period is never cut short. An illegal setting raises an error flag and is dropped, and the values already in use stay active.

Top module: `pll_fbdiv_top`

## Requirements
- R1: With swallow count A and main count B active, consecutive feedback pulses are exactly 32·B + A input cycles apart, and each pulse is one cycle wide.
- R2: With A = 0 every prescaler cycle counts 32, so the feedback period is 32·B.
- R3: With A = B − 1, the largest legal swallow count for a given B, the feedback period is 33·B − 1.
- R4: A legal feedback load takes effect at the first period boundary after the load cycle. The period in progress keeps its old length, and the settings stay the same between boundaries.
- R5: A feedback load with B < 3 or A ≥ B sets the feedback error flag (n_err = 1) in the cycle after the load, and the previous A and B stay in use. With no load, n_err holds its value.
- R6: A legal feedback load clears n_err in the cycle after the load. A legal reference load clears r_err in the same way.
- R7: The reference pulse repeats every R input cycles and is one cycle wide. A reference load with R < 3 sets r_err and keeps the previous R. A legal R takes effect at the next reference boundary.
- R8: After synchronous reset, A = 0, B = 3 and R = 3 are active, so the periods are 96 and 3. Both error flags are 0, and fb_pulse is low in the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| ld_n | input | 1 | Load strobe for the feedback setting |
| cfg_a | input | 5 | Swallow count A |
| cfg_b | input | 8 | Main count B |
| ld_r | input | 1 | Load strobe for the reference setting |
| cfg_r | input | 6 | Reference count R |
| fb_pulse | output | 1 | One-cycle pulse per feedback period |
| ref_pulse | output | 1 | One-cycle pulse per reference period |
| n_err | output | 1 | Last feedback load was illegal |
| r_err | output | 1 | Last reference load was illegal |

## Verification
The hardest case to reach from the ports is a new setting that arrives partway through a period. The measured period that straddles the load must keep its old length, and only the period after the next pulse may change. The stimulus finds a pulse, waits a fixed number of cycles, issues the load, and then times both the straddling period and the next one. Random legal settings are mixed with directed extremes (A = 0, A = B − 1, B = 255). Illegal loads are placed after a known setting, so that the unchanged period shows the old values stayed in force.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
    localparam int PRE_LOG = 5;
    localparam int PRE_DIV = 1 << PRE_LOG;
    localparam int PC_W    = PRE_LOG + 1;
    localparam int A_W     = 5;
    localparam int B_W     = 8;
    localparam int R_W     = 6;
    localparam int B_MIN   = 3;
    localparam int R_MIN   = 3;
    localparam int DEF_A   = 0;
    localparam int DEF_B   = 3;
    localparam int DEF_R   = 3;
    localparam int N_W     = A_W + B_W;

    typedef logic [A_W-1:0] swal_t;
    typedef logic [B_W-1:0] main_t;
    typedef logic [R_W-1:0] refc_t;

    typedef struct packed {
        main_t b;
        swal_t a;
    } ncfg_t;

    function automatic logic ncfg_ok(input ncfg_t c);
        return (c.b >= main_t'(B_MIN)) && (main_t'(c.a) < c.b);
    endfunction

    function automatic logic rcfg_ok(input refc_t r);
        return r >= refc_t'(R_MIN);
    endfunction
endpackage

// File: rtl/fbdiv_cfg_hold.sv
module fbdiv_cfg_hold #(
    parameter int          W     = 8,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic         legal,
    input  logic [W-1:0] din,
    input  logic         bnd,
    output logic [W-1:0] act,
    output logic         err
);
    logic [W-1:0] pend;
    logic         pend_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            act    <= INIT;
            pend   <= INIT;
            pend_v <= 1'b0;
            err    <= 1'b0;
        end else begin
            if (bnd && pend_v)
                act <= pend;
            if (ld && legal) begin
                pend   <= din;
                pend_v <= 1'b1;
            end else if (bnd) begin
                pend_v <= 1'b0;
            end
            if (ld)
                err <= !legal;
        end
    end
endmodule

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler
    import fbdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mod33,
    output logic tc
);
    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] last;

    assign last = mod33 ? PC_W'(PRE_DIV) : PC_W'(PRE_DIV - 1);
    assign tc   = (pc == last);

    always_ff @(posedge clk) begin
        if (rst)      pc <= '0;
        else if (tc)  pc <= '0;
        else          pc <= pc + PC_W'(1);
    end
endmodule

// File: rtl/fbdiv_swallow.sv
module fbdiv_swallow
    import fbdiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pre_tc,
    input  swal_t a,
    input  main_t b,
    output logic  mod33,
    output logic  period_end
);
    main_t mc;

    assign mod33      = (mc < main_t'(a));
    assign period_end = pre_tc && (mc == b - main_t'(1));

    always_ff @(posedge clk) begin
        if (rst)              mc <= '0;
        else if (period_end)  mc <= '0;
        else if (pre_tc)      mc <= mc + main_t'(1);
    end
endmodule

// File: rtl/fbdiv_refdiv.sv
module fbdiv_refdiv
    import fbdiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  refc_t r,
    output logic  tc
);
    refc_t rc;

    assign tc = (rc == r - refc_t'(1));

    always_ff @(posedge clk) begin
        if (rst)     rc <= '0;
        else if (tc) rc <= '0;
        else         rc <= rc + refc_t'(1);
    end
endmodule

// File: rtl/pll_fbdiv_top.sv
module pll_fbdiv_top
    import fbdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_n,
    input  logic [A_W-1:0]   cfg_a,
    input  logic [B_W-1:0]   cfg_b,
    input  logic             ld_r,
    input  logic [R_W-1:0]   cfg_r,
    output logic             fb_pulse,
    output logic             ref_pulse,
    output logic             n_err,
    output logic             r_err
);
    localparam ncfg_t N_INIT = '{b: main_t'(DEF_B), a: swal_t'(DEF_A)};

    ncfg_t n_in;
    ncfg_t n_act;
    refc_t r_act;
    logic  mod33;
    logic  pre_tc;
    logic  fb_end;
    logic  ref_end;

    assign n_in = '{b: cfg_b, a: cfg_a};

    fbdiv_cfg_hold #(.W(N_W), .INIT(N_INIT)) u_ncfg (
        .clk(clk), .rst(rst), .ld(ld_n), .legal(ncfg_ok(n_in)),
        .din(n_in), .bnd(fb_end), .act(n_act), .err(n_err)
    );

    fbdiv_cfg_hold #(.W(R_W), .INIT(refc_t'(DEF_R))) u_rcfg (
        .clk(clk), .rst(rst), .ld(ld_r), .legal(rcfg_ok(cfg_r)),
        .din(cfg_r), .bnd(ref_end), .act(r_act), .err(r_err)
    );

    fbdiv_prescaler u_pre (
        .clk(clk), .rst(rst), .mod33(mod33), .tc(pre_tc)
    );

    fbdiv_swallow u_swal (
        .clk(clk), .rst(rst), .pre_tc(pre_tc), .a(n_act.a), .b(n_act.b),
        .mod33(mod33), .period_end(fb_end)
    );

    fbdiv_refdiv u_ref (
        .clk(clk), .rst(rst), .r(r_act), .tc(ref_end)
    );

    assign fb_pulse  = fb_end;
    assign ref_pulse = ref_end;
endmodule

// File: rtl/pll_fbdiv_chk.sv
module pll_fbdiv_chk
    import fbdiv_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           ld_n,
    input logic [A_W-1:0] cfg_a,
    input logic [B_W-1:0] cfg_b,
    input logic           ld_r,
    input logic [R_W-1:0] cfg_r,
    input logic           fb_pulse,
    input logic           ref_pulse,
    input logic           n_err,
    input logic           r_err,
    input ncfg_t          n_act,
    input refc_t          r_act
);
    logic n_good, r_good;
    assign n_good = (cfg_b >= B_MIN[B_W-1:0]) && ({3'b000, cfg_a} < cfg_b);
    assign r_good = (cfg_r >= R_MIN[R_W-1:0]);

    p_fb_one_wide_r1: assert property (@(posedge clk) disable iff (rst)
        fb_pulse |=> !fb_pulse);
    p_n_bad_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (ld_n && !n_good) |=> n_err);
    p_n_err_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !ld_n |=> $stable(n_err));
    p_n_good_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (ld_n && n_good) |=> !n_err);
    p_r_good_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (ld_r && r_good) |=> !r_err);
    p_n_swap_at_end_r4: assert property (@(posedge clk) disable iff (rst)
        !fb_pulse |=> $stable(n_act));
    p_n_act_legal_r5: assert property (@(posedge clk) disable iff (rst)
        (n_act.b >= B_MIN[B_W-1:0]) && ({3'b000, n_act.a} < n_act.b));
    p_r_bad_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (ld_r && !r_good) |=> r_err);
    p_ref_one_wide_r7: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |=> !ref_pulse);
    p_r_swap_at_end_r7: assert property (@(posedge clk) disable iff (rst)
        !ref_pulse |=> $stable(r_act));
endmodule

bind pll_fbdiv_top pll_fbdiv_chk u_chk (
    .clk(clk), .rst(rst), .ld_n(ld_n), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .ld_r(ld_r), .cfg_r(cfg_r), .fb_pulse(fb_pulse), .ref_pulse(ref_pulse),
    .n_err(n_err), .r_err(r_err), .n_act(n_act), .r_act(r_act)
);

// File: tb/tb_pll_fbdiv_top.sv
module tb_pll_fbdiv_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_n = 1'b0;
    logic [4:0] cfg_a = '0;
    logic [7:0] cfg_b = '0;
    logic       ld_r = 1'b0;
    logic [5:0] cfg_r = '0;
    logic       fb_pulse, ref_pulse, n_err, r_err;

    int total = 0;
    int bad   = 0;
    int wd    = 0;
    int cur_n = 96;

    always #2 clk = ~clk;

    pll_fbdiv_top dut (
        .clk(clk), .rst(rst), .ld_n(ld_n), .cfg_a(cfg_a), .cfg_b(cfg_b),
        .ld_r(ld_r), .cfg_r(cfg_r), .fb_pulse(fb_pulse), .ref_pulse(ref_pulse),
        .n_err(n_err), .r_err(r_err)
    );

    function automatic int exp_n(input int a, input int b);
        return 32 * b + a;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_n(input int a, input int b);
        @(negedge clk);
        ld_n = 1'b1; cfg_a = 5'(a); cfg_b = 8'(b);
        @(negedge clk);
        ld_n = 1'b0;
    endtask

    task automatic load_r(input int r);
        @(negedge clk);
        ld_r = 1'b1; cfg_r = 6'(r);
        @(negedge clk);
        ld_r = 1'b0;
    endtask

    task automatic fb_len(output int len);
        while (!fb_pulse) @(negedge clk);
        len = 0;
        do begin @(negedge clk); len++; end while (!fb_pulse);
    endtask

    task automatic ref_len(output int len);
        while (!ref_pulse) @(negedge clk);
        len = 0;
        do begin @(negedge clk); len++; end while (!ref_pulse);
    endtask

    task automatic set_and_check(input int a, input int b, input string req);
        int len;
        load_n(a, b);
        chk(n_err == 1'b0, req, int'(n_err), 0);
        fb_len(len);
        cur_n = exp_n(a, b);
        chk(len == cur_n, req, len, cur_n);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=0", wd);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int len, a, b, old_n, cnt;
        void'($urandom(32'd5030));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        chk(n_err == 1'b0 && r_err == 1'b0, "R8 flags", int'({n_err, r_err}), 0);
        chk(fb_pulse == 1'b0, "R8 first cycle", int'(fb_pulse), 0);
        fb_len(len);
        chk(len == 96, "R8 default N", len, 96);
        ref_len(len);
        chk(len == 3, "R8 default R", len, 3);

        // R2 A=0, R3 A=B-1, R1 extremes
        set_and_check(0, 7, "R2 A=0");
        set_and_check(6, 7, "R3 A=B-1");
        set_and_check(2, 3, "R3 A=B-1 minB");
        set_and_check(31, 255, "R1 max");
        set_and_check(0, 3, "R2 minimum");

        // R1 random legal settings
        for (int i = 0; i < 12; i++) begin
            b = 3 + int'($urandom_range(37));
            a = int'($urandom_range((b - 1 > 31) ? 31 : b - 1));
            set_and_check(a, b, "R1 random");
        end

        // R4 load mid-period: running period keeps old length
        old_n = cur_n;
        while (!fb_pulse) @(negedge clk);
        cnt = 0;
        repeat (10) begin @(negedge clk); cnt++; end
        ld_n = 1'b1; cfg_a = 5'd4; cfg_b = 8'd9;
        @(negedge clk); cnt++;
        ld_n = 1'b0;
        while (!fb_pulse) begin @(negedge clk); cnt++; end
        chk(cnt == old_n, "R4 running period", cnt, old_n);
        fb_len(len);
        cur_n = exp_n(4, 9);
        chk(len == cur_n, "R4 next period", len, cur_n);

        // R5 illegal loads keep old values
        load_n(0, 2);
        chk(n_err == 1'b1, "R5 B<3 flag", int'(n_err), 1);
        fb_len(len);
        chk(len == cur_n, "R5 B<3 kept", len, cur_n);
        load_n(5, 5);
        chk(n_err == 1'b1, "R5 A=B flag", int'(n_err), 1);
        repeat (5) @(negedge clk);
        chk(n_err == 1'b1, "R5 flag holds", int'(n_err), 1);
        fb_len(len);
        chk(len == cur_n, "R5 A=B kept", len, cur_n);

        // R6 legal load clears the flag
        set_and_check(1, 4, "R6 clear");

        // R7 reference divider
        load_r(17);
        chk(r_err == 1'b0, "R7 legal R", int'(r_err), 0);
        ref_len(len);
        chk(len == 17, "R7 R=17", len, 17);
        load_r(2);
        chk(r_err == 1'b1, "R7 R<3 flag", int'(r_err), 1);
        ref_len(len);
        chk(len == 17, "R7 R kept", len, 17);
        load_r(63);
        chk(r_err == 1'b0, "R6 r_err clear", int'(r_err), 0);
        ref_len(len);
        chk(len == 63, "R7 R=63", len, 63);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule